// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit takes a single trap request and performs the whole state change of trap entry in one clock edge. The request carries an interrupt flag, a cause number, the program counter of the trapping instruction, a faulting address and the current privilege level. The unit normalises the cause and decides whether a supervisor handler or a machine handler takes the trap. It then records cause, return address and trap value in the chosen level's registers, pushes the interrupt-enable and previous-privilege stack in the status word, and computes the handler address. The privilege switches to the handler's level.

The delegation masks, both trap vector registers and the status word come in from the surrounding control-register file. The unit returns registered copies: the updated status word, the supervisor and machine cause/EPC/tval registers, the new program counter and the new privilege. Privilege encoding is U=0, S=1, M=3; the value 2 is never presented. Nothing changes on a cycle where `trap_valid` is low.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, `priv_q` is 3 (machine) and `status_q`, `pc_q` and all six cause/EPC/tval outputs are zero.
- R2: An interrupt (`trap_is_irq`=1) looks up its delegation bit in `mideleg`. An exception looks it up in `medeleg`.
- R3: A trap goes to the supervisor level only when `cur_priv` is 0 or 1, the cause is below 32, and the mask bit indexed by the cause is 1. Every other trap goes to the machine level, including a cause of 32 or more whose low five bits select a set mask bit.
- R4: For a supervisor-level trap, status bit 5 takes bit 1, bit 8 takes `cur_priv[0]`, and bit 1 is cleared. For a machine-level trap, bit 7 takes bit 3, bits 12:11 take `cur_priv`, and bit 3 is cleared. All other status bits are copied from `status_in`.
- R5: The target level's cause register gets the effective cause in its low bits, with bit 31 equal to `trap_is_irq`. Its EPC register gets `pc_in`.
- R6: The target level's tval register gets `fault_addr` for exceptions with effective cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. It gets zero for every other exception and for every interrupt.
- R7: An exception with cause 8 is an environment call. Its effective cause is 8, 9 or 11 when `cur_priv` is 0, 1 or 3, and this effective cause is also the one used for delegation.
- R8: `pc_q` becomes the target vector register with bits 1:0 cleared. When that register's bits 1:0 equal 1 and the trap is an interrupt, 4 times the cause is added.
- R9: `priv_q` becomes 1 for a supervisor-level trap and 3 for a machine-level trap.
- R10: The cause, EPC and tval registers of the level that did not take the trap keep their values. While `trap_valid` is 0, every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Commit a trap entry on this edge |
| trap_is_irq | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause | input | 6 | Raw cause number |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| pc_in | input | 32 | PC of the trapping instruction |
| fault_addr | input | 32 | Faulting address for address-type causes |
| status_in | input | 32 | Current status word |
| medeleg | input | 32 | Exception delegation mask |
| mideleg | input | 32 | Interrupt delegation mask |
| mtvec | input | 32 | Machine trap vector |
| stvec | input | 32 | Supervisor trap vector |
| priv_q | output | 2 | Privilege after trap |
| status_q | output | 32 | Updated status word |
| scause_q | output | 32 | Supervisor cause register |
| sepc_q | output | 32 | Supervisor exception PC |
| stval_q | output | 32 | Supervisor trap value |
| mcause_q | output | 32 | Machine cause register |
| mepc_q | output | 32 | Machine exception PC |
| mtval_q | output | 32 | Machine trap value |
| pc_q | output | 32 | Handler address |

## Verification
The assertions assume that `cur_priv` never carries the reserved value 2 while `trap_valid` is high. They also assume that every input is stable and defined from before the first clock edge. The stimulus drives all inputs on falling edges from known values and uses only the privilege codes 0, 1 and 3. It pulses `trap_valid` for exactly one cycle per request, so each assertion sees one commit followed by at least one idle cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // status word bit positions (decoded by neighbouring logic)
  localparam int unsigned ST_SIE    = 1;
  localparam int unsigned ST_MIE    = 3;
  localparam int unsigned ST_SPIE   = 5;
  localparam int unsigned ST_MPIE   = 7;
  localparam int unsigned ST_SPP    = 8;
  localparam int unsigned ST_MPP_LO = 11;

  localparam int unsigned ENV_CALL_CODE = 8;

  // exception codes whose trap value is the faulting address
  function automatic logic code_has_addr(input int unsigned code);
    case (code)
      0, 1, 4, 5, 6, 7, 12, 13, 15: code_has_addr = 1'b1;
      default:                      code_has_addr = 1'b0;
    endcase
  endfunction

  // environment call code by current privilege
  function automatic int unsigned env_call_code(input logic [1:0] priv);
    case (priv)
      2'd1:    env_call_code = 9;
      2'd3:    env_call_code = 11;
      default: env_call_code = 8;
    endcase
  endfunction

endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] raw_cause,
  input  logic [1:0]         cur_priv,
  input  logic [XLEN-1:0]    fault_addr,
  output logic [CAUSE_W-1:0] eff_cause,
  output logic [XLEN-1:0]    tval_sel
);

  logic is_ecall;
  assign is_ecall = !is_irq && (32'(raw_cause) == ENV_CALL_CODE);

  always_comb begin
    eff_cause = is_ecall ? CAUSE_W'(env_call_code(cur_priv)) : raw_cause;
    tval_sel  = (!is_irq && code_has_addr(32'(eff_cause))) ? fault_addr : '0;
  end

  always_comb begin
    if (is_irq) assert_irq_no_tval_R6: assert (tval_sel == '0);
  end

endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [1:0]         cur_priv,
  input  logic [XLEN-1:0]    medeleg,
  input  logic [XLEN-1:0]    mideleg,
  output logic               to_s
);

  localparam int unsigned IDX_W = $clog2(XLEN);

  logic [XLEN-1:0] mask;
  logic            in_range;
  logic            low_priv;
  logic            mask_bit;

  assign mask     = is_irq ? mideleg : medeleg;
  assign in_range = 32'(cause) < 32'(XLEN);
  assign low_priv = (cur_priv == PRIV_U) || (cur_priv == PRIV_S);

  generate
    if (CAUSE_W > IDX_W) begin : g_wide
      assign mask_bit = in_range && mask[cause[IDX_W-1:0]];
    end else begin : g_narrow
      assign mask_bit = mask[IDX_W'(cause)];
    end
  endgenerate

  assign to_s = low_priv && mask_bit;

  always_comb begin
    if (cur_priv == PRIV_M) assert_machine_never_delegates_R3: assert (!to_s);
  end

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic [XLEN-1:0]    tvec,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    new_pc
);

  localparam logic [1:0] MODE_VECTORED = 2'b01;

  function automatic logic [XLEN-1:0] handler_addr(
      input logic [XLEN-1:0] vec, input logic irq, input logic [CAUSE_W-1:0] c);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] off;
    base = {vec[XLEN-1:2], 2'b00};
    off  = {{(XLEN-CAUSE_W-2){1'b0}}, c, 2'b00};
    handler_addr = (irq && vec[1:0] == MODE_VECTORED) ? base + off : base;
  endfunction

  assign new_pc = handler_addr(tvec, is_irq, cause);

  always_comb begin
    assert_handler_aligned_R8: assert (new_pc[1:0] == 2'b00);
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [1:0]         cur_priv,
  input  logic [XLEN-1:0]    pc_in,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic [XLEN-1:0]    status_in,
  input  logic [XLEN-1:0]    medeleg,
  input  logic [XLEN-1:0]    mideleg,
  input  logic [XLEN-1:0]    mtvec,
  input  logic [XLEN-1:0]    stvec,
  output logic [1:0]         priv_q,
  output logic [XLEN-1:0]    status_q,
  output logic [XLEN-1:0]    scause_q,
  output logic [XLEN-1:0]    sepc_q,
  output logic [XLEN-1:0]    stval_q,
  output logic [XLEN-1:0]    mcause_q,
  output logic [XLEN-1:0]    mepc_q,
  output logic [XLEN-1:0]    mtval_q,
  output logic [XLEN-1:0]    pc_q
);

  // named internal events
  logic [CAUSE_W-1:0] eff_cause;
  logic [XLEN-1:0]    tval_sel;
  logic               trap_to_s;
  logic [XLEN-1:0]    s_target_pc;
  logic [XLEN-1:0]    m_target_pc;
  logic               commit_s;
  logic               commit_m;

  trap_cause_fix #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_fix (
    .is_irq     (trap_is_irq),
    .raw_cause  (trap_cause),
    .cur_priv   (cur_priv),
    .fault_addr (fault_addr),
    .eff_cause  (eff_cause),
    .tval_sel   (tval_sel)
  );

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .is_irq   (trap_is_irq),
    .cause    (eff_cause),
    .cur_priv (cur_priv),
    .medeleg  (medeleg),
    .mideleg  (mideleg),
    .to_s     (trap_to_s)
  );

  trap_vector_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_svec (
    .tvec   (stvec),
    .is_irq (trap_is_irq),
    .cause  (eff_cause),
    .new_pc (s_target_pc)
  );

  trap_vector_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_mvec (
    .tvec   (mtvec),
    .is_irq (trap_is_irq),
    .cause  (eff_cause),
    .new_pc (m_target_pc)
  );

  assign commit_s = trap_valid && trap_to_s;
  assign commit_m = trap_valid && !trap_to_s;

  function automatic logic [XLEN-1:0] push_status(
      input logic [XLEN-1:0] st, input logic to_s, input logic [1:0] priv);
    logic [XLEN-1:0] r;
    r = st;
    if (to_s) begin
      r[ST_SPIE] = st[ST_SIE];
      r[ST_SPP]  = priv[0];
      r[ST_SIE]  = 1'b0;
    end else begin
      r[ST_MPIE]        = st[ST_MIE];
      r[ST_MPP_LO +: 2] = priv;
      r[ST_MIE]         = 1'b0;
    end
    push_status = r;
  endfunction

  function automatic logic [XLEN-1:0] cause_word(
      input logic irq, input logic [CAUSE_W-1:0] c);
    cause_word = {irq, {(XLEN-1-CAUSE_W){1'b0}}, c};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q   <= PRIV_M;
      status_q <= '0;
      pc_q     <= '0;
    end else if (trap_valid) begin
      priv_q   <= trap_to_s ? PRIV_S : PRIV_M;
      status_q <= push_status(status_in, trap_to_s, cur_priv);
      pc_q     <= trap_to_s ? s_target_pc : m_target_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scause_q <= '0;
      sepc_q   <= '0;
      stval_q  <= '0;
    end else if (commit_s) begin
      scause_q <= cause_word(trap_is_irq, eff_cause);
      sepc_q   <= pc_in;
      stval_q  <= tval_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcause_q <= '0;
      mepc_q   <= '0;
      mtval_q  <= '0;
    end else if (commit_m) begin
      mcause_q <= cause_word(trap_is_irq, eff_cause);
      mepc_q   <= pc_in;
      mtval_q  <= tval_sel;
    end
  end

  // assertions
  assert_priv_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> cur_priv != PRIV_RSVD);

  assert_priv_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> priv_q == ($past(trap_to_s) ? PRIV_S : PRIV_M));

  assert_mie_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_m |=> !status_q[ST_MIE]);

  assert_sie_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_s |=> !status_q[ST_SIE]);

  assert_sepc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_s |=> sepc_q == $past(pc_in));

  assert_mepc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_m |=> mepc_q == $past(pc_in));

  assert_mtval_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_m && trap_is_irq |=> mtval_q == '0);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> $stable(pc_q) && $stable(priv_q) && $stable(status_q));

  assert_m_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_s |=> $stable(mcause_q) && $stable(mepc_q) && $stable(mtval_q));

endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic        trap_is_irq = 1'b0;
  logic [5:0]  trap_cause = '0;
  logic [1:0]  cur_priv = 2'd3;
  logic [31:0] pc_in = '0, fault_addr = '0, status_in = '0;
  logic [31:0] medeleg = 32'h0000_2308;   // bits 3,8,9,13
  logic [31:0] mideleg = 32'h0000_0222;   // bits 1,5,9
  logic [31:0] mtvec   = 32'h4000_2003;   // mode 3: not vectored
  logic [31:0] stvec   = 32'h8000_1001;   // mode 1: vectored
  logic [1:0]  priv_q;
  logic [31:0] status_q, scause_q, sepc_q, stval_q, mcause_q, mepc_q, mtval_q, pc_q;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  trap_entry_unit uut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
    .trap_cause(trap_cause), .cur_priv(cur_priv), .pc_in(pc_in), .fault_addr(fault_addr),
    .status_in(status_in), .medeleg(medeleg), .mideleg(mideleg), .mtvec(mtvec),
    .stvec(stvec), .priv_q(priv_q), .status_q(status_q), .scause_q(scause_q),
    .sepc_q(sepc_q), .stval_q(stval_q), .mcause_q(mcause_q), .mepc_q(mepc_q),
    .mtval_q(mtval_q), .pc_q(pc_q)
  );

  // {irq, cause[5:0], priv[1:0], exp_to_s, exp_cause[5:0]}
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 6'd13, 2'd0, 1'b1, 6'd13},  // R3 delegated page fault
    {1'b0, 6'd13, 2'd3, 1'b0, 6'd13},  // R3 machine never delegates
    {1'b0, 6'd2,  2'd1, 1'b0, 6'd2 },  // R3 bit clear
    {1'b0, 6'd8,  2'd0, 1'b1, 6'd8 },  // R7 ecall from U
    {1'b0, 6'd8,  2'd1, 1'b1, 6'd9 },  // R7 ecall from S
    {1'b0, 6'd8,  2'd3, 1'b0, 6'd11},  // R7 ecall from M
    {1'b1, 6'd5,  2'd0, 1'b1, 6'd5 },  // R8 vectored S irq
    {1'b1, 6'd7,  2'd1, 1'b0, 6'd7 },  // R8 mode 3 not vectored
    {1'b1, 6'd9,  2'd1, 1'b1, 6'd9 },
    {1'b0, 6'd3,  2'd0, 1'b1, 6'd3 },  // R2 medeleg bit 3
    {1'b1, 6'd3,  2'd0, 1'b0, 6'd3 },  // R2 mideleg bit 3 clear
    {1'b0, 6'd1,  2'd1, 1'b0, 6'd1 },  // R2 mideleg bit 1 ignored for exc
    {1'b0, 6'd40, 2'd0, 1'b0, 6'd40},  // R3 out of range cause
    {1'b1, 6'd1,  2'd3, 1'b0, 6'd1 },
    {1'b0, 6'd15, 2'd0, 1'b0, 6'd15}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pc(input logic [31:0] v, input logic irq, input logic [5:0] c);
    logic [31:0] b;
    b = v & ~32'd3;
    if (irq && v[1:0] == 2'd1) b = b + 32'(c) * 4;
    return b;
  endfunction

  function automatic logic [31:0] exp_tval(input logic irq, input logic [5:0] c, input logic [31:0] a);
    if (!irq && (c inside {6'd0, 6'd1, 6'd4, 6'd5, 6'd6, 6'd7, 6'd12, 6'd13, 6'd15})) return a;
    return 32'd0;
  endfunction

  function automatic logic [31:0] exp_status(input logic [31:0] st, input logic s, input logic [1:0] p);
    logic [31:0] r;
    r = st;
    if (s) begin r[5] = st[1]; r[8] = p[0]; r[1] = 1'b0; end
    else   begin r[7] = st[3]; r[12:11] = p; r[3] = 1'b0; end
    return r;
  endfunction

  task automatic fire;
    @(negedge clk) trap_valid = 1'b1;
    @(posedge clk);
    @(negedge clk) trap_valid = 1'b0;
  endtask

  task automatic run_vec(input int i, input logic irq, input logic [5:0] c,
                         input logic [1:0] p, input logic es, input logic [5:0] ec);
    logic [31:0] o_sc, o_se, o_st, o_mc, o_me, o_mt, cw, tv, st_in;
    o_sc = scause_q; o_se = sepc_q; o_st = stval_q;
    o_mc = mcause_q; o_me = mepc_q; o_mt = mtval_q;
    st_in = (i % 2 == 0) ? 32'h0000_00AA : 32'h5A5A_1F55;
    @(negedge clk);
    trap_is_irq = irq; trap_cause = c; cur_priv = p;
    pc_in = 32'h1000_0000 + 32'(i) * 4; fault_addr = 32'hDEAD_0000 + 32'(i);
    status_in = st_in;
    fire();
    cw = {irq, 25'd0, ec};
    tv = exp_tval(irq, ec, fault_addr);
    chk("R9 priv", 32'(priv_q), es ? 32'd1 : 32'd3);
    chk("R4 status", status_q, exp_status(st_in, es, p));
    chk("R8 pc", pc_q, exp_pc(es ? stvec : mtvec, irq, ec));
    if (es) begin
      chk("R5 R7 scause", scause_q, cw);
      chk("R5 sepc", sepc_q, pc_in);
      chk("R6 stval", stval_q, tv);
      chk("R10 mcause kept", mcause_q, o_mc);
      chk("R10 mepc kept", mepc_q, o_me);
      chk("R10 mtval kept", mtval_q, o_mt);
    end else begin
      chk("R5 R7 mcause", mcause_q, cw);
      chk("R5 mepc", mepc_q, pc_in);
      chk("R6 mtval", mtval_q, tv);
      chk("R10 scause kept", scause_q, o_sc);
      chk("R10 sepc kept", sepc_q, o_se);
      chk("R10 stval kept", stval_q, o_st);
    end
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] h_pc, h_st, h_mc;
    logic [1:0]  h_pr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 priv", 32'(priv_q), 32'd3);
    chk("R1 pc", pc_q, 32'd0);
    chk("R1 status", status_q, 32'd0);
    chk("R1 scause", scause_q, 32'd0);
    chk("R1 mcause", mcause_q, 32'd0);
    chk("R1 mepc", mepc_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(i, VEC[i][15], VEC[i][14:9], VEC[i][8:7], VEC[i][6], VEC[i][5:0]);
    end

    // R8 vectored machine interrupt
    mtvec = 32'h4000_2001;
    run_vec(20, 1'b1, 6'd11, 2'd3, 1'b0, 6'd11);
    // R8 vectored mode does not apply to exceptions
    run_vec(21, 1'b0, 6'd5, 2'd3, 1'b0, 6'd5);

    // R10 idle cycles ignore changing inputs
    h_pc = pc_q; h_st = status_q; h_mc = mcause_q; h_pr = priv_q;
    @(negedge clk);
    trap_cause = 6'd2; cur_priv = 2'd0; pc_in = 32'h7777_0000; status_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R10 idle pc", pc_q, h_pc);
    chk("R10 idle status", status_q, h_st);
    chk("R10 idle mcause", mcause_q, h_mc);
    chk("R10 idle priv", 32'(h_pr), 32'(priv_q));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule